// File: doc/BRIEF.md
# Interrupt Vector Selector

This block turns a group of level-sensitive interrupt lines into one interrupt request for a processor core, together with the number of the line to service and the address of that line's handler. Each clock edge copies the lines into a pending field, and also copies the per-line enable mask, the global enable, the debug-mode flag, the handler base address and the spacing code. A line counts as live when its pending bit and its enable bit are both set. A request is raised when at least one line is live, the global enable is set and the core is not in debug mode.

When several lines are live, the line with the highest number wins. The handler address is the base address plus a slot offset. The slot number is the fixed cause offset for external interrupts (64) plus the winning line number. The spacing code is an exponent: code V gives a stride of 4·2^V bytes, and code 0 gives a stride of zero, so every line then uses the base address itself. All outputs come from registered state, so they change one cycle after the inputs do. Saving the core's state when the interrupt is taken is left to the core.

Top module: `irq_vec_sel`

## Requirements
- R1: Pending bit N follows interrupt input N with one cycle of latency. Raising the input sets the bit and lowering it clears the bit, and the request and line number outputs reflect the new value at the next clock edge.
- R2: Input bits at positions NUM_LINES (13) and above have no effect. Driving only those bits leaves the request low and the line number at 0.
- R3: The request is high only when the AND of the pending field and the enable mask is nonzero.
- R4: The request is high only when the captured global enable is 1 and the captured debug flag is 0. Otherwise the request stays low, even with live lines.
- R5: The line number output is the highest bit position set in (pending AND enable mask). It is 0 when no line is live.
- R6: When the spacing code is 0, the address output equals the handler base address, whatever line is selected.
- R7: When the spacing code V is nonzero, the address output is base + (64 + line number) × (4 << V), truncated to ADDR_W (32) bits.
- R8: While reset is asserted, the pending field, enable mask, spacing code, base, global enable and debug flag are all held at 0. The request, line number and address outputs therefore read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | IN_W (16) | Interrupt lines; only the low NUM_LINES bits are used |
| line_en | input | NUM_LINES (13) | Per-line enable mask |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Debug mode flag; blocks the request when set |
| entry_base | input | ADDR_W (32) | Handler base address |
| vs_sel | input | VS_W (3) | Spacing exponent code |
| irq_req | output | 1 | Interrupt request |
| irq_idx | output | IDX_W (4) | Selected line number |
| vec_addr | output | ADDR_W (32) | Handler address of the selected line |

## Verification
Priority selection and request gating can both change in the same cycle. The bench provokes this in two ways. First, it lowers the highest live line on the same edge that it raises a lower line and raises the global enable. Second, it drops the debug flag on the same edge that a new line arrives. In both cases the expected line number, request and address come from the inputs applied before that single edge. A design that mixes old and new state, or that gates the request one cycle late, fails these checks.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   // one slot unit is a four-byte word
   localparam int unsigned SLOT_UNIT_SHIFT = 2;
   // cause offset applied to external interrupt lines
   localparam int unsigned EXT_CAUSE_BASE  = 64;
endpackage

// File: rtl/irq_pend_cap.sv
module irq_pend_cap #(
   parameter int unsigned NUM_LINES = 13,
   parameter int unsigned IN_W      = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned VS_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IN_W-1:0]      irq_in,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 glb_ie,
   input  logic                 dbg_mode,
   input  logic [ADDR_W-1:0]    entry_base,
   input  logic [VS_W-1:0]      vs_sel,
   output logic [NUM_LINES-1:0] pend_q,
   output logic [NUM_LINES-1:0] mask_q,
   output logic                 gate_q,
   output logic [ADDR_W-1:0]    base_q,
   output logic [VS_W-1:0]      vs_q
);
   // lines above NUM_LINES are dropped here
   logic [NUM_LINES-1:0] used_lines;
   assign used_lines = irq_in[NUM_LINES-1:0];

   logic [IN_W-NUM_LINES:0] spare_unused;
   assign spare_unused = {irq_in[IN_W-1:NUM_LINES-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         gate_q <= 1'b0;
         base_q <= '0;
         vs_q   <= '0;
      end else begin
         pend_q <= used_lines;
         mask_q <= line_en;
         gate_q <= glb_ie & ~dbg_mode;
         base_q <= entry_base;
         vs_q   <= vs_sel;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_LINES = 13,
   parameter int unsigned IDX_W     = 4
) (
   input  logic [NUM_LINES-1:0] live,
   output logic                 any_live,
   output logic [IDX_W-1:0]     top_idx
);
   // ascending scan: the last hit is the highest line
   always_comb begin
      top_idx = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (live[i]) top_idx = IDX_W'(i);
      end
   end

   assign any_live = |live;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned VS_W       = 3,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned CAUSE_BASE = 64
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [VS_W-1:0]   vs,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   import irq_vec_pkg::*;

   localparam int unsigned SH_W = VS_W + 2;

   logic [ADDR_W-1:0] slot;
   logic [SH_W-1:0]   shamt;
   logic [ADDR_W-1:0] offset;

   generate
      if (CAUSE_BASE == 0) begin : g_no_cause
         assign slot = ADDR_W'(idx);
      end else begin : g_cause
         assign slot = ADDR_W'(CAUSE_BASE) + ADDR_W'(idx);
      end
   endgenerate

   assign shamt  = SH_W'(vs) + SH_W'(SLOT_UNIT_SHIFT);
   assign offset = (vs == '0) ? '0 : (slot << shamt);
   assign addr   = base + offset;
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
   parameter int unsigned NUM_LINES  = 13,
   parameter int unsigned IN_W       = 16,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned VS_W       = 3,
   parameter int unsigned CAUSE_BASE = irq_vec_pkg::EXT_CAUSE_BASE,
   localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IN_W-1:0]      irq_in,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 glb_ie,
   input  logic                 dbg_mode,
   input  logic [ADDR_W-1:0]    entry_base,
   input  logic [VS_W-1:0]      vs_sel,
   output logic                 irq_req,
   output logic [IDX_W-1:0]     irq_idx,
   output logic [ADDR_W-1:0]    vec_addr
);
   generate
      if (NUM_LINES < 2 || NUM_LINES >= IN_W) begin : g_bad_lines
         $error("irq_vec_sel: NUM_LINES must be at least 2 and below IN_W");
      end
      if (VS_W < 1 || VS_W > 4) begin : g_bad_vs
         $error("irq_vec_sel: VS_W must lie in 1..4");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("irq_vec_sel: ADDR_W too small");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] mask_q;
   logic                 gate_q;
   logic [ADDR_W-1:0]    base_q;
   logic [VS_W-1:0]      vs_q;
   logic [NUM_LINES-1:0] live;
   logic                 any_live;

   irq_pend_cap #(
      .NUM_LINES (NUM_LINES),
      .IN_W      (IN_W),
      .ADDR_W    (ADDR_W),
      .VS_W      (VS_W)
   ) cap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .line_en    (line_en),
      .glb_ie     (glb_ie),
      .dbg_mode   (dbg_mode),
      .entry_base (entry_base),
      .vs_sel     (vs_sel),
      .pend_q     (pend_q),
      .mask_q     (mask_q),
      .gate_q     (gate_q),
      .base_q     (base_q),
      .vs_q       (vs_q)
   );

   assign live = pend_q & mask_q;

   irq_prio_pick #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) pick_i (
      .live     (live),
      .any_live (any_live),
      .top_idx  (irq_idx)
   );

   irq_vec_addr #(
      .ADDR_W     (ADDR_W),
      .VS_W       (VS_W),
      .IDX_W      (IDX_W),
      .CAUSE_BASE (CAUSE_BASE)
   ) addr_i (
      .base (base_q),
      .vs   (vs_q),
      .idx  (irq_idx),
      .addr (vec_addr)
   );

   assign irq_req = any_live & gate_q;
endmodule

// File: rtl/irq_vec_sel_chk.sv
module irq_vec_sel_chk #(
   parameter int unsigned NUM_LINES = 13,
   parameter int unsigned IN_W      = 16,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned VS_W      = 3,
   parameter int unsigned IDX_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [IN_W-1:0]      irq_in,
   input logic [NUM_LINES-1:0] line_en,
   input logic                 glb_ie,
   input logic                 dbg_mode,
   input logic [ADDR_W-1:0]    entry_base,
   input logic [VS_W-1:0]      vs_sel,
   input logic                 irq_req,
   input logic [IDX_W-1:0]     irq_idx,
   input logic [ADDR_W-1:0]    vec_addr
);
   // checker's own view of what the inputs were one edge earlier
   logic [NUM_LINES-1:0] seen_live;
   logic                 seen_open;
   logic                 seen_vs0;
   logic [ADDR_W-1:0]    seen_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_live <= '0;
         seen_open <= 1'b0;
         seen_vs0  <= 1'b1;
         seen_base <= '0;
      end else begin
         seen_live <= irq_in[NUM_LINES-1:0] & line_en;
         seen_open <= glb_ie & ~dbg_mode;
         seen_vs0  <= (vs_sel == '0);
         seen_base <= entry_base;
      end
   end

   a_r1_live_raises_req: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_live != '0 && seen_open) |-> irq_req);

   a_r3_no_live_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_live == '0) |-> !irq_req);

   a_r4_req_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> seen_open);

   a_r5_highest_line: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_live != '0) |-> ((seen_live >> irq_idx) == NUM_LINES'(1)));

   a_r6_zero_stride: assert property (@(posedge clk) disable iff (!rst_n)
      seen_vs0 |-> (vec_addr == seen_base));
endmodule

bind irq_vec_sel irq_vec_sel_chk #(
   .NUM_LINES (NUM_LINES),
   .IN_W      (IN_W),
   .ADDR_W    (ADDR_W),
   .VS_W      (VS_W),
   .IDX_W     (IDX_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_in     (irq_in),
   .line_en    (line_en),
   .glb_ie     (glb_ie),
   .dbg_mode   (dbg_mode),
   .entry_base (entry_base),
   .vs_sel     (vs_sel),
   .irq_req    (irq_req),
   .irq_idx    (irq_idx),
   .vec_addr   (vec_addr)
);

// File: tb/irq_vec_sel_tb_top.sv
module irq_vec_sel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 13;
   localparam int WATCHDOG_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic [12:0] line_en = '0;
   logic        glb_ie = 1'b0;
   logic        dbg_mode = 1'b0;
   logic [31:0] entry_base = '0;
   logic [2:0]  vs_sel = '0;
   logic        irq_req;
   logic [3:0]  irq_idx;
   logic [31:0] vec_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vec_sel dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .line_en    (line_en),
      .glb_ie     (glb_ie),
      .dbg_mode   (dbg_mode),
      .entry_base (entry_base),
      .vs_sel     (vs_sel),
      .irq_req    (irq_req),
      .irq_idx    (irq_idx),
      .vec_addr   (vec_addr)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge capture, check at the next falling edge
   task automatic step(input string tag, input logic [15:0] li, input logic [12:0] en,
                       input logic g, input logic d, input logic [31:0] b,
                       input logic [2:0] v);
      logic [12:0] live;
      logic [3:0]  eidx;
      logic        ereq;
      logic [31:0] stride;
      logic [31:0] eaddr;
      irq_in = li; line_en = en; glb_ie = g; dbg_mode = d; entry_base = b; vs_sel = v;
      @(posedge clk);
      @(negedge clk);
      live = li[12:0] & en;
      eidx = '0;
      for (int i = 0; i < NL; i++) if (live[i]) eidx = 4'(i);
      ereq   = (live != '0) && g && !d;
      stride = (v == 3'd0) ? 32'd0 : (32'd4 << v);
      eaddr  = b + (32'd64 + 32'(eidx)) * stride;
      chk(tag, "irq_req", 32'(irq_req), 32'(ereq));
      chk(tag, "irq_idx", 32'(irq_idx), 32'(eidx));
      chk(tag, "vec_addr", vec_addr, eaddr);
   endtask

   task automatic t_reset;
      irq_in = 16'hFFFF; line_en = '1; glb_ie = 1'b1; entry_base = 32'h1234_5678; vs_sel = 3'd5;
      @(posedge clk);
      @(negedge clk);
      chk("R8", "irq_req", 32'(irq_req), 32'd0);
      chk("R8", "irq_idx", 32'(irq_idx), 32'd0);
      chk("R8", "vec_addr", vec_addr, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_follow;
      step("R1", 16'h0001, '1, 1'b1, 1'b0, 32'h1C00_0000, 3'd1);
      step("R1", 16'h0020, '1, 1'b1, 1'b0, 32'h1C00_0000, 3'd1);
      step("R1", 16'h0000, '1, 1'b1, 1'b0, 32'h1C00_0000, 3'd1);
   endtask

   task automatic t_range;
      step("R2", 16'hE000, '1, 1'b1, 1'b0, 32'h0000_4000, 3'd2);
      step("R2", 16'hA004, '1, 1'b1, 1'b0, 32'h0000_4000, 3'd2);
   endtask

   task automatic t_mask;
      step("R3", 16'h0F00, 13'h00FF, 1'b1, 1'b0, 32'h0000_8000, 3'd3);
      step("R3", 16'h0F00, 13'h0200, 1'b1, 1'b0, 32'h0000_8000, 3'd3);
   endtask

   task automatic t_gate;
      step("R4", 16'h0010, '1, 1'b0, 1'b0, 32'h0001_0000, 3'd1);
      step("R4", 16'h0010, '1, 1'b1, 1'b1, 32'h0001_0000, 3'd1);
      step("R4", 16'h0010, '1, 1'b0, 1'b1, 32'h0001_0000, 3'd1);
      step("R4", 16'h0010, '1, 1'b1, 1'b0, 32'h0001_0000, 3'd1);
   endtask

   task automatic t_prio;
      step("R5", 16'h1FFF, '1, 1'b1, 1'b0, 32'h0002_0000, 3'd2);
      step("R5", 16'h0003, '1, 1'b1, 1'b0, 32'h0002_0000, 3'd2);
      step("R5", 16'h0841, 13'h07FF, 1'b1, 1'b0, 32'h0002_0000, 3'd2);
   endtask

   task automatic t_vs0;
      step("R6", 16'h1000, '1, 1'b1, 1'b0, 32'h9000_0000, 3'd0);
      step("R6", 16'h0002, '1, 1'b1, 1'b0, 32'h9000_0040, 3'd0);
   endtask

   task automatic t_stride;
      for (int v = 1; v < 8; v++) begin
         step("R7", 16'h0100 >> (v % 4), '1, 1'b1, 1'b0, 32'h1C00_0000, 3'(v));
      end
      step("R7", 16'h1000, '1, 1'b1, 1'b0, 32'hFFFF_FF00, 3'd7);
   endtask

   // priority change and gating change land on the same edge
   task automatic t_collide;
      step("R5", 16'h1000, '1, 1'b0, 1'b0, 32'h0004_0000, 3'd1);
      step("R4", 16'h0008, '1, 1'b1, 1'b0, 32'h0004_0000, 3'd1);
      step("R4", 16'h0000, '1, 1'b1, 1'b1, 32'h0004_0000, 3'd1);
      step("R1", 16'h0400, '1, 1'b1, 1'b0, 32'h0004_0000, 3'd1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_follow();
      t_range();
      t_mask();
      t_gate();
      t_prio();
      t_vs0();
      t_stride();
      t_collide();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog: actual=%0d cycles expected=fewer", WATCHDOG_CYCLES);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule